// File: doc/BRIEF.md
# Load-Multiple User-Bank Sequencer

This block is the micro-sequencer a simple 32-bit core hands one decoded "load multiple into the user-bank registers" operation to. It takes the register list, the two addressing bits (pre/post and up/down), the base register index, the base value read from the current mode's bank, the condition result and the current processor mode. It works out the first word address and then reads one word per selected register over a ready/valid memory port. Each returned word leaves the block as a one-cycle write strobe. The strobe carries the destination index and a tag that names the user-mode bank, whatever mode the core is in.

The block never writes an updated base value back. It refuses the operation in three ways. In hypervisor mode it raises an undefined-instruction trap. In user or system mode, or when the list or base index is unusable, it completes as a no-operation. When the condition fails it simply completes. In all three cases it makes no memory access.

Top module: `ldm_user_seq`

## Requirements
- R1: With N the number of set bits among reg_list[14:0], the first read address is base_val when up=1 and base_val-4N when up=0. It is a further 4 higher when pre equals up. The sum wraps modulo 2^32.
- R2: Reads cover the selected registers in ascending index order, so the lowest index uses the lowest address. Each following read address is 4 above the previous one.
- R3: reg_list[15] is ignored. It adds no read, it never appears as wr_idx=15, and a list holding only bit 15 counts as empty.
- R4: Every returned word gives exactly one wr_en pulse, with wr_data equal to the word, wr_idx equal to its register and wr_mode=5'b10000 (user bank). An operation makes exactly N writes and never writes back the base.
- R5: When cond_ok=1 and mode=5'b11010 (hypervisor), the cycle after start shows done=1 and undef_trap=1, and no memory request is made.
- R6: When cond_ok=1 and mode is 5'b10000 (user) or 5'b11111 (system), the cycle after start shows done=1 and nop_done=1, with no read and no write.
- R7: In any other mode with cond_ok=1, an empty list (bits 0 to 14 clear) or base_idx=15 gives done=1 and nop_done=1 in the cycle after start, with no read and no write.
- R8: When cond_ok=0 the cycle after start shows done=1, undef_trap=0 and nop_done=0, with no read and no write. This check comes before R5, which comes before R6 and R7.
- R9: At most one read is in flight. mem_req_valid is raised only while busy, and it stays high with mem_addr stable until mem_req_ready is seen.
- R10: After reset busy, done, mem_req_valid and wr_en are low. While the block is running busy is high. done is a single-cycle pulse in the cycle after the last word returns, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, taken when not busy |
| cond_ok | input | 1 | Condition check passed |
| mode | input | 5 | Current processor mode |
| reg_list | input | 16 | Register selection list |
| pre | input | 1 | Address step before transfer (P) |
| up | input | 1 | Ascending block above base (U) |
| base_idx | input | 4 | Base register index |
| base_val | input | 32 | Base value from current bank |
| busy | output | 1 | Operation running |
| done | output | 1 | Completion pulse |
| undef_trap | output | 1 | Undefined-instruction trap, with done |
| nop_done | output | 1 | Completed as no-operation, with done |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | 32 | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Destination register index |
| wr_mode | output | 5 | Bank tag of the write (user) |
| wr_data | output | 32 | Write data |

## Verification
A refused or conditionally skipped operation reports in the cycle after the start edge: done, undef_trap and nop_done are all due there, and the bench samples them at the next falling edge. The first request is already valid one cycle after start and keeps its address until an edge where ready is high. A write strobe is combinational from the response, so the bench checks it 1 ns after driving mem_rsp_valid. The done pulse is due one cycle after the last response and is checked at that falling edge and again one cycle later. Counters clocked at the rising edge confirm that refused operations make no request cycle and no write.

// File: rtl/ldm_user_seq.sv
module ldm_user_seq #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned IDXW = 4,
  parameter int unsigned MW = 5,
  parameter int unsigned WORD_BYTES = 4,
  parameter logic [MW-1:0] MODE_USR = 5'h10,
  parameter logic [MW-1:0] MODE_SYS = 5'h1F,
  parameter logic [MW-1:0] MODE_HYP = 5'h1A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cond_ok,
  input  logic [MW-1:0]   mode,
  input  logic [NREG-1:0] reg_list,
  input  logic            pre,
  input  logic            up,
  input  logic [IDXW-1:0] base_idx,
  input  logic [XLEN-1:0] base_val,
  output logic            busy,
  output logic            done,
  output logic            undef_trap,
  output logic            nop_done,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [MW-1:0]   wr_mode,
  output logic [XLEN-1:0] wr_data
);
  localparam int unsigned SCAN = NREG - 1;
  localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t            state;
  logic [SCAN-1:0]   pend;
  logic [SCAN-1:0]   pend_clr;
  logic [XLEN-1:0]   addr;
  logic              done_q, trap_q, nop_q;
  logic [SCAN-1:0]   scan;
  logic [IDXW:0]     cnt;
  logic [XLEN-1:0]   len, low_addr, first_addr;
  logic              refuse_mode, refuse_op;
  logic              unused_pc_bit;

  function automatic logic [IDXW-1:0] lowest(input logic [SCAN-1:0] v);
    lowest = '0;
    for (int i = SCAN - 1; i >= 0; i--)
      if (v[i]) lowest = IDXW'(i);
  endfunction

  function automatic logic [IDXW:0] count_ones(input logic [SCAN-1:0] v);
    count_ones = '0;
    for (int i = 0; i < SCAN; i++)
      count_ones = count_ones + (IDXW+1)'(v[i]);
  endfunction

  assign scan          = reg_list[SCAN-1:0];
  assign unused_pc_bit = reg_list[NREG-1];
  assign cnt           = count_ones(scan);
  assign len           = XLEN'(cnt) * XLEN'(WORD_BYTES);
  assign low_addr      = up ? base_val : base_val - len;
  assign first_addr    = (pre == up) ? low_addr + XLEN'(WORD_BYTES) : low_addr;
  assign refuse_mode   = (mode == MODE_USR) || (mode == MODE_SYS);
  assign refuse_op     = refuse_mode || (base_idx == PC_IDX) || (scan == '0);

  assign pend_clr      = pend & (pend - SCAN'(1));

  assign busy          = (state != S_IDLE);
  assign done          = done_q;
  assign undef_trap    = trap_q;
  assign nop_done      = nop_q;
  assign mem_req_valid = (state == S_REQ);
  assign mem_addr      = addr;
  assign wr_en         = (state == S_WAIT) && mem_rsp_valid;
  assign wr_idx        = lowest(pend);
  assign wr_mode       = wr_en ? MODE_USR : '0;
  assign wr_data       = mem_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pend   <= '0;
      addr   <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
      nop_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      nop_q  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (!cond_ok) begin
            done_q <= 1'b1;
          end else if (mode == MODE_HYP) begin
            done_q <= 1'b1;
            trap_q <= 1'b1;
          end else if (refuse_op) begin
            done_q <= 1'b1;
            nop_q  <= 1'b1;
          end else begin
            pend  <= scan;
            addr  <= first_addr;
            state <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          pend <= pend_clr;
          addr <= addr + XLEN'(WORD_BYTES);
          if (pend_clr == '0) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldm_user_seq_chk.sv
module ldm_user_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cond_ok,
  input logic [4:0]  mode,
  input logic        busy,
  input logic        done,
  input logic        undef_trap,
  input logic        nop_done,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_addr,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [4:0]  wr_mode
);
  logic [31:0] last_addr;
  logic        have_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      have_last <= 1'b0;
      last_addr <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      have_last <= 1'b1;
      last_addr <= mem_addr;
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    have_last && mem_req_valid |-> mem_addr == last_addr + 32'd4);
  p_no_pc_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx != 4'd15);
  p_user_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy && wr_mode == 5'h10);
  p_hyp_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && cond_ok && mode == 5'h1A |=> undef_trap && done && !busy);
  p_trap_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap |-> done && !nop_done);
  p_nop_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nop_done |-> done && !mem_req_valid);
  p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !cond_ok |=> done && !undef_trap && !nop_done && !busy);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req_valid && !wr_en);
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind ldm_user_seq ldm_user_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cond_ok(cond_ok), .mode(mode),
  .busy(busy), .done(done), .undef_trap(undef_trap), .nop_done(nop_done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_addr(mem_addr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode)
);

// File: tb/ldm_user_seq_tb_top.sv
`timescale 1ns/1ps
module ldm_user_seq_tb_top;
  localparam logic [4:0] USR = 5'h10, SYS = 5'h1F, HYP = 5'h1A;
  localparam logic [4:0] SVC = 5'h13, IRQ = 5'h12, FIQ = 5'h11, ABT = 5'h17, UND = 5'h1B;

  logic clk = 0, rst_n = 0, start = 0, cond_ok = 0, pre = 0, up = 0;
  logic [4:0] mode = SVC;
  logic [15:0] reg_list = '0;
  logic [3:0] base_idx = '0;
  logic [31:0] base_val = '0;
  logic busy, done, undef_trap, nop_done, mem_req_valid, wr_en;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_addr, wr_data, mem_rsp_data = '0;
  logic [3:0] wr_idx;
  logic [4:0] wr_mode;

  int checks = 0, errors = 0, wr_cnt = 0, req_cyc = 0;

  ldm_user_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cond_ok(cond_ok), .mode(mode),
    .reg_list(reg_list), .pre(pre), .up(up), .base_idx(base_idx), .base_val(base_val),
    .busy(busy), .done(done), .undef_trap(undef_trap), .nop_done(nop_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (wr_en) wr_cnt++;
    if (mem_req_valid) req_cyc++;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pop15(input logic [15:0] l);
    pop15 = 0;
    for (int i = 0; i < 15; i++) pop15 += int'(l[i]);
  endfunction

  function automatic logic [31:0] first_of(input logic [31:0] b, input logic [15:0] l, input logic p, input logic u);
    logic [31:0] a;
    a = u ? b : b - 32'(4 * pop15(l));
    if (p == u) a = a + 32'd4;
    return a;
  endfunction

  function automatic logic [31:0] memw(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic run_op(input logic [15:0] l, input logic p, input logic u, input logic [3:0] bi,
                        input logic [31:0] bv, input logic c, input logic [4:0] md);
    int n;
    logic tr, np, acc;
    logic [31:0] a;
    n  = pop15(l);
    tr = c && md == HYP;
    np = c && !tr && (md == USR || md == SYS || bi == 4'd15 || n == 0);
    a  = first_of(bv, l, p, u);
    @(negedge clk);
    wr_cnt = 0; req_cyc = 0;
    reg_list = l; pre = p; up = u; base_idx = bi; base_val = bv; cond_ok = c; mode = md;
    start = 1;
    @(negedge clk);
    start = 0;
    if (!c || tr || np) begin
      check(done == 1'b1, "R8/R5/R6/R7 done after refusal", 32'(done), 1);
      check(undef_trap == tr, "R5 trap flag", 32'(undef_trap), 32'(tr));
      check(nop_done == np, "R6/R7 nop flag", 32'(nop_done), 32'(np));
      check(busy == 1'b0, "R10 idle after refusal", 32'(busy), 0);
      @(negedge clk);
      check(req_cyc == 0 && wr_cnt == 0, "R5/R8 no access", 32'(req_cyc + wr_cnt), 0);
      check(done == 1'b0, "R10 done one cycle", 32'(done), 0);
    end else begin
      check(busy == 1'b1, "R10 busy while running", 32'(busy), 1);
      for (int i = 0; i < 15; i++) begin
        if (l[i]) begin
          acc = 0;
          while (!acc) begin
            mem_req_ready = ($urandom % 3) != 0;
            #1;
            check(mem_req_valid == 1'b1, "R9 request pending", 32'(mem_req_valid), 1);
            check(mem_addr == a, "R1/R2 read address", mem_addr, a);
            acc = mem_req_ready && mem_req_valid;
            @(negedge clk);
          end
          mem_req_ready = 0;
          repeat ($urandom % 3) begin
            check(mem_req_valid == 1'b0, "R9 one in flight", 32'(mem_req_valid), 0);
            @(negedge clk);
          end
          mem_rsp_valid = 1; mem_rsp_data = memw(a);
          #1;
          check(wr_en == 1'b1, "R4 write strobe", 32'(wr_en), 1);
          check(wr_idx == 4'(i), "R2/R3 write index", 32'(wr_idx), 32'(i));
          check(wr_data == memw(a), "R4 write data", wr_data, memw(a));
          check(wr_mode == USR, "R4 user bank tag", 32'(wr_mode), 32'(USR));
          @(negedge clk);
          mem_rsp_valid = 0;
          a = a + 32'd4;
        end
      end
      check(done && !busy && !undef_trap && !nop_done, "R10 done after last word",
            {28'd0, done, busy, undef_trap, nop_done}, 32'h8);
      @(negedge clk);
      check(done == 1'b0, "R10 done one cycle", 32'(done), 0);
      check(wr_cnt == n, "R4 write count equals list size", 32'(wr_cnt), 32'(n));
    end
  endtask

  function automatic logic [4:0] pick_mode();
    case ($urandom % 10)
      0: return USR;
      1: return SYS;
      2: return HYP;
      3: return IRQ;
      4: return FIQ;
      5: return ABT;
      6: return UND;
      default: return SVC;
    endcase
  endfunction

  initial begin
    logic [15:0] l;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && mem_req_valid == 0 && wr_en == 0, "R10 reset state",
          {28'd0, busy, done, mem_req_valid, wr_en}, 0);
    rst_n = 1;
    // R1 R2: all four addressing modes
    run_op(16'h8421, 0, 0, 4'd2, 32'h2000, 1, SVC);
    run_op(16'h8421, 1, 0, 4'd2, 32'h2000, 1, SVC);
    run_op(16'h8421, 0, 1, 4'd2, 32'h2000, 1, IRQ);
    run_op(16'h8421, 1, 1, 4'd2, 32'h2000, 1, FIQ);
    // R1: wrap below zero, full list
    run_op(16'h7FFF, 1, 0, 4'd0, 32'h4, 1, ABT);
    run_op(16'hFFFF, 1, 1, 4'd13, 32'hFFFF_FFF8, 1, UND);
    // R3: only PC bit set counts as empty
    run_op(16'h8000, 0, 1, 4'd1, 32'h100, 1, SVC);
    // R7: empty list and base index 15
    run_op(16'h0000, 0, 1, 4'd1, 32'h100, 1, SVC);
    run_op(16'h00FF, 0, 1, 4'd15, 32'h100, 1, SVC);
    // R5 R6 R8
    run_op(16'h00FF, 0, 1, 4'd1, 32'h100, 1, HYP);
    run_op(16'h00FF, 0, 1, 4'd1, 32'h100, 1, USR);
    run_op(16'h00FF, 0, 1, 4'd1, 32'h100, 1, SYS);
    run_op(16'h00FF, 0, 1, 4'd1, 32'h100, 0, HYP);
    // R4: base register inside the list is loaded once, never written back
    run_op(16'h0038, 0, 1, 4'd4, 32'h3000, 1, SVC);
    for (int k = 0; k < 300; k++) begin
      case ($urandom % 4)
        0: l = 16'($urandom);
        1: l = 16'(1) << ($urandom % 16);
        2: l = 16'($urandom) & 16'($urandom);
        default: l = 16'($urandom) | 16'h7000;
      endcase
      run_op(l, 1'($urandom), 1'($urandom), 4'($urandom), $urandom & 32'hFFFF_FFFC,
             ($urandom % 10) != 0, pick_mode());
    end
    summary();
    $finish;
  end
endmodule